// File: doc/BRIEF.md
# Single-Cycle Execute and Writeback Datapath

This block is the execute and writeback half of a 32-bit single-cycle processor core. Each cycle it receives an instruction word, already fetched, and a set of decoded control bits. It reads two source registers, forms the second ALU operand from either a register or an extended 16-bit immediate, and computes an add, subtract or bitwise OR. It can read or write a small data memory. At the clock edge that closes the cycle, it writes back either the ALU result or the loaded word.

A register-equality flag is produced combinationally so that the fetch unit can resolve conditional branches in the same cycle. Fetch, next-PC selection and control decoding sit outside this block. The two read buses, the ALU result and the writeback value are brought out as ports. The fetch side and the checking side can observe them there.

Top module: `exec_datapath`

## Requirements
- R1: While rst_ni is low, every register is cleared, so every register reads zero after reset.
- R2: A register is written only at the rising clk_i edge that ends the cycle, and only when reg_wr_i is 1. With reg_wr_i at 0 no register changes.
- R3: The write destination is the rt field (bits 20:16) when reg_dst_i is 0, and the rd field (bits 15:11) when reg_dst_i is 1.
- R4: The immediate is bits 15:0. It is zero-extended when ext_op_i is 0 and sign-extended when ext_op_i is 1.
- R5: The second ALU operand is bus B when alu_src_i is 0, and the extended immediate when alu_src_i is 1.
- R6: alu_ctrl_i selects the ALU operation: 2'b00 adds, 2'b01 subtracts (A minus operand), 2'b10 is bitwise OR, and 2'b11 adds. Sums and differences wrap modulo 2^32.
- R7: The writeback value wb_o is the ALU result when mem_to_reg_i is 0, and the data memory read word when mem_to_reg_i is 1.
- R8: The data memory holds 256 words. It is indexed by ALU result bits 9:2, so addresses that differ only outside those bits alias. It reads combinationally and stores bus B at the clock edge only when mem_wr_i is 1.
- R9: Register 0 always reads zero, and writes aimed at it have no effect.
- R10: equal_o is 1 exactly when the two register read values are identical, within the same cycle.
- R11: Bus A carries the register named by bits 25:21 (rs). Bus B carries the register named by bits 20:16 (rt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes occur on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of the register file |
| instr_i | input | 32 | Current instruction word |
| reg_dst_i | input | 1 | Destination select: 0 rt, 1 rd |
| reg_wr_i | input | 1 | Register write enable |
| alu_src_i | input | 1 | Second operand select: 0 bus B, 1 immediate |
| ext_op_i | input | 1 | Immediate extension: 0 zero, 1 sign |
| alu_ctrl_i | input | 2 | ALU operation select |
| mem_wr_i | input | 1 | Data memory write enable |
| mem_to_reg_i | input | 1 | Writeback select: 0 ALU, 1 memory |
| equal_o | output | 1 | Bus A equals bus B |
| bus_a_o | output | 32 | rs read value |
| bus_b_o | output | 32 | rt read value |
| alu_o | output | 32 | ALU result (also memory address) |
| wb_o | output | 32 | Value to be written back |

## Verification
The assertions check several things on every cycle: register 0 reads zero, equality tracks the two read buses, the OR and SUB results agree with the buses, sign extension appears in the upper half of the result, and register contents stay put across a cycle without a write enable. The bench scenarios are the only way to show the things that need a stored value to come back later. These are destination selection between rt and rd, store followed by load, aliasing of addresses in the memory, the effect of a suppressed memory write, and the zeroing performed by reset.

// File: rtl/exec_dp_pkg.sv
package exec_dp_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned RADDR_W = 5;
  localparam int unsigned IMM_W   = 16;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_OR   = 2'b10,
    ALU_ADD2 = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic [5:0]         op;
    logic [RADDR_W-1:0] rs;
    logic [RADDR_W-1:0] rt;
    logic [RADDR_W-1:0] rd;
    logic [4:0]         shamt;
    logic [5:0]         funct;
  } instr_t;
endpackage

// File: rtl/exec_regfile.sv
module exec_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ra_i,
  input  logic [ADDR_W-1:0] rb_i,
  input  logic [ADDR_W-1:0] rw_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  localparam int unsigned NREGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [NREGS];

  // entry 0 is a constant; no storage
  assign regs_q[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[g] <= '0;
      else if (we_i && rw_i == ADDR_W'(g))            regs_q[g] <= wd_i;
    end
  end

  assign a_o = regs_q[ra_i];
  assign b_o = regs_q[rb_i];
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_dp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              ext_sign_i,
  input  logic              use_imm_i,
  input  logic [1:0]        op_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext, opnd;

  assign imm_ext = {{PAD_W{ext_sign_i & imm_i[IMM_W-1]}}, imm_i};
  assign opnd    = use_imm_i ? imm_ext : b_i;

  always_comb begin
    unique case (alu_op_e'(op_i))
      ALU_SUB: y_o = a_i - opnd;
      ALU_OR:  y_o = a_i | opnd;
      default: y_o = a_i + opnd;
    endcase
  end
endmodule

// File: rtl/exec_dmem.sv
module exec_dmem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 256
) (
  input  logic              clk_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned LSB   = $clog2(DATA_W / 8);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx = addr_i[LSB +: IDX_W];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx] <= wd_i;
  end

  assign rd_o = mem_q[idx];
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_dp_pkg::*;
#(
  parameter int unsigned MEM_DEPTH = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] instr_i,
  input  logic            reg_dst_i,
  input  logic            reg_wr_i,
  input  logic            alu_src_i,
  input  logic            ext_op_i,
  input  logic [1:0]      alu_ctrl_i,
  input  logic            mem_wr_i,
  input  logic            mem_to_reg_i,
  output logic            equal_o,
  output logic [XLEN-1:0] bus_a_o,
  output logic [XLEN-1:0] bus_b_o,
  output logic [XLEN-1:0] alu_o,
  output logic [XLEN-1:0] wb_o
);
  instr_t             fld;
  logic [RADDR_W-1:0] dest;
  logic [XLEN-1:0]    rd_a, rd_b, alu_y, mem_rd, wb;

  assign fld  = instr_t'(instr_i);
  assign dest = reg_dst_i ? fld.rd : fld.rt;

  exec_regfile #(.DATA_W(XLEN), .ADDR_W(RADDR_W)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (fld.rs),
    .rb_i  (fld.rt),
    .rw_i  (dest),
    .we_i  (reg_wr_i),
    .wd_i  (wb),
    .a_o   (rd_a),
    .b_o   (rd_b)
  );

  exec_alu #(.DATA_W(XLEN), .IMM_W(IMM_W)) u_alu (
    .a_i       (rd_a),
    .b_i       (rd_b),
    .imm_i     (instr_i[IMM_W-1:0]),
    .ext_sign_i(ext_op_i),
    .use_imm_i (alu_src_i),
    .op_i      (alu_ctrl_i),
    .y_o       (alu_y)
  );

  exec_dmem #(.DATA_W(XLEN), .DEPTH(MEM_DEPTH)) u_dmem (
    .clk_i (clk_i),
    .addr_i(alu_y),
    .we_i  (mem_wr_i),
    .wd_i  (rd_b),
    .rd_o  (mem_rd)
  );

  assign wb      = mem_to_reg_i ? mem_rd : alu_y;
  assign equal_o = (rd_a == rd_b);
  assign bus_a_o = rd_a;
  assign bus_b_o = rd_b;
  assign alu_o   = alu_y;
  assign wb_o    = wb;
endmodule

// File: rtl/exec_datapath_chk.sv
module exec_datapath_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] instr_i,
  input logic        reg_wr_i,
  input logic        alu_src_i,
  input logic        ext_op_i,
  input logic [1:0]  alu_ctrl_i,
  input logic        equal_o,
  input logic [31:0] bus_a_o,
  input logic [31:0] bus_b_o,
  input logic [31:0] alu_o
);
  // R9, R11: rs field of zero always yields zero on bus A
  a_r9_zero_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[25:21] == 5'd0 |-> bus_a_o == '0);

  // R10
  a_r10_equal_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    equal_o == (bus_a_o == bus_b_o));

  // R2: no write enable, same operands -> both buses unchanged next cycle
  a_r2_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(reg_wr_i) && instr_i == $past(instr_i)) |->
      ($stable(bus_a_o) && $stable(bus_b_o)));

  // R5, R6
  a_r6_or_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_src_i && alu_ctrl_i == 2'b10) |-> alu_o == (bus_a_o | bus_b_o));

  a_r6_sub_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_src_i && alu_ctrl_i == 2'b01) |-> alu_o == bus_a_o - bus_b_o);

  // R4: r0 + sign-extended immediate replicates bit 15 upward
  a_r4_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_src_i && ext_op_i && alu_ctrl_i == 2'b00 && instr_i[25:21] == 5'd0)
      |-> alu_o[31:16] == {16{instr_i[15]}});

  a_r4_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_src_i && !ext_op_i && alu_ctrl_i == 2'b00 && instr_i[25:21] == 5'd0)
      |-> alu_o[31:16] == 16'h0);
endmodule

bind exec_datapath exec_datapath_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .instr_i   (instr_i),
  .reg_wr_i  (reg_wr_i),
  .alu_src_i (alu_src_i),
  .ext_op_i  (ext_op_i),
  .alu_ctrl_i(alu_ctrl_i),
  .equal_o   (equal_o),
  .bus_a_o   (bus_a_o),
  .bus_b_o   (bus_b_o),
  .alu_o     (alu_o)
);

// File: tb/exec_datapath_test.sv
module exec_datapath_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr = '0;
  logic        reg_dst = 0, reg_wr = 0, alu_src = 0, ext_op = 0;
  logic [1:0]  alu_ctrl = 2'b00;
  logic        mem_wr = 0, mem_to_reg = 0;
  logic        equal;
  logic [31:0] bus_a, bus_b, alu, wb;

  always #4 clk = ~clk; // 125 MHz

  exec_datapath uut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr),
    .reg_dst_i(reg_dst), .reg_wr_i(reg_wr), .alu_src_i(alu_src),
    .ext_op_i(ext_op), .alu_ctrl_i(alu_ctrl), .mem_wr_i(mem_wr),
    .mem_to_reg_i(mem_to_reg), .equal_o(equal), .bus_a_o(bus_a),
    .bus_b_o(bus_b), .alu_o(alu), .wb_o(wb)
  );

  typedef struct {
    string       tag;
    logic [31:0] a, b, y, w;
    logic        eq;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] m_rf [32];
  logic [31:0] m_mem [256];
  int          n_chk = 0, n_err = 0;
  event        sample_ev;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per issued instruction
  initial forever begin
    @(sample_ev);
    #2;
    begin
      exp_t e;
      e = sb_q.pop_front();
      cmp(e.tag, "bus_a", bus_a, e.a);
      cmp(e.tag, "bus_b", bus_b, e.b);
      cmp(e.tag, "alu", alu, e.y);
      cmp(e.tag, "wb", wb, e.w);
      cmp(e.tag, "equal", {31'd0, equal}, {31'd0, e.eq});
    end
  end

  task automatic issue(string tag, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm,
                       logic rdst, logic rwr, logic asrc, logic eop, logic [1:0] actl,
                       logic mwr, logic m2r);
    exp_t        e;
    logic [31:0] ext, op2;
    logic [4:0]  dst;
    @(negedge clk);
    instr = {6'd0, rs, rt, imm};
    reg_dst = rdst; reg_wr = rwr; alu_src = asrc; ext_op = eop;
    alu_ctrl = actl; mem_wr = mwr; mem_to_reg = m2r;
    e.tag = tag;
    e.a   = (rs == 0) ? 32'd0 : m_rf[rs];
    e.b   = (rt == 0) ? 32'd0 : m_rf[rt];
    ext   = eop ? {{16{imm[15]}}, imm} : {16'd0, imm};
    op2   = asrc ? ext : e.b;
    case (actl)
      2'b01:   e.y = e.a - op2;
      2'b10:   e.y = e.a | op2;
      default: e.y = e.a + op2;
    endcase
    e.w  = m2r ? m_mem[e.y[9:2]] : e.y;
    e.eq = (e.a == e.b);
    sb_q.push_back(e);
    -> sample_ev;
    dst = rdst ? imm[15:11] : rt;
    if (rwr && dst != 0) m_rf[dst] = e.w;
    if (mwr) m_mem[e.y[9:2]] = e.b;
  endtask

  // rd encoded in imm[15:11]
  function automatic logic [15:0] rd_f(logic [4:0] rd);
    return {rd, 11'd0};
  endfunction

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: all registers zero after reset
    issue("R1_reset_r3_r4", 5'd3, 5'd4, 16'd0, 0, 0, 0, 0, 2'b00, 0, 0);
    issue("R1_reset_r31", 5'd31, 5'd17, 16'd0, 0, 0, 0, 0, 2'b00, 0, 0);
    // R4 zero ext, R3 rt dest: r1 = 0x8001
    issue("R4_zero_ext", 5'd0, 5'd1, 16'h8001, 0, 1, 1, 0, 2'b10, 0, 0);
    // R4 sign ext: r2 = 0xFFFFFFFC
    issue("R4_sign_ext", 5'd0, 5'd2, 16'hFFFC, 0, 1, 1, 1, 2'b00, 0, 0);
    // R3 rd dest, R6 add, R11 buses: r3 = r1 + r2
    issue("R3_rd_dest_add", 5'd1, 5'd2, rd_f(5'd3), 1, 1, 0, 0, 2'b00, 0, 0);
    issue("R11_read_r3", 5'd3, 5'd1, 16'd0, 0, 0, 0, 0, 2'b00, 0, 0);
    // R6 sub wrap: r4 = r1 - r2 ; r5 = r2 - r1
    issue("R6_sub", 5'd1, 5'd2, rd_f(5'd4), 1, 1, 0, 0, 2'b01, 0, 0);
    issue("R6_sub_neg", 5'd2, 5'd1, rd_f(5'd5), 1, 1, 0, 0, 2'b01, 0, 0);
    // R6 code 11 adds; R5 register operand
    issue("R6_code3_add", 5'd4, 5'd5, 16'd0, 0, 0, 0, 0, 2'b11, 0, 0);
    issue("R5_or_regs", 5'd1, 5'd2, 16'd0, 0, 0, 0, 0, 2'b10, 0, 0);
    // R9: write to r0 ignored
    issue("R9_write_r0", 5'd1, 5'd0, 16'h1234, 0, 1, 1, 0, 2'b10, 0, 0);
    issue("R9_read_r0", 5'd0, 5'd0, 16'd0, 0, 0, 0, 0, 2'b00, 0, 0);
    // R2: reg_wr=0 leaves r6 unchanged
    issue("R2_no_write", 5'd1, 5'd6, 16'h00FF, 0, 0, 1, 0, 2'b10, 0, 0);
    issue("R2_read_r6", 5'd6, 5'd6, 16'd0, 0, 0, 0, 0, 2'b00, 0, 0);
    // R8 store then R7 load
    issue("R8_store", 5'd0, 5'd3, 16'h0010, 0, 0, 1, 0, 2'b00, 1, 0);
    issue("R7_load", 5'd0, 5'd7, 16'h0010, 0, 1, 1, 0, 2'b00, 0, 1);
    issue("R7_read_r7", 5'd7, 5'd3, 16'd0, 0, 0, 0, 0, 2'b00, 0, 0);
    // R8 aliasing: 0x410 hits same word as 0x10
    issue("R8_alias_load", 5'd0, 5'd8, 16'h0410, 0, 1, 1, 0, 2'b00, 0, 1);
    // R8 mem_wr=0 does not store
    issue("R8_store_blocked", 5'd0, 5'd2, 16'h0010, 0, 0, 1, 0, 2'b00, 0, 0);
    issue("R8_after_blocked", 5'd0, 5'd9, 16'h0010, 0, 0, 1, 0, 2'b00, 0, 1);
    // R8 store using base register, sign-extended negative offset
    issue("R8_store_neg_off", 5'd1, 5'd2, 16'hFFF0, 0, 0, 1, 1, 2'b00, 1, 0);
    issue("R8_load_neg_off", 5'd1, 5'd0, 16'hFFF0, 0, 0, 1, 1, 2'b00, 0, 1);
    // R10 equality
    issue("R10_equal_same", 5'd1, 5'd1, 16'd0, 0, 0, 0, 0, 2'b00, 0, 0);
    issue("R10_equal_diff", 5'd1, 5'd2, 16'd0, 0, 0, 0, 0, 2'b00, 0, 0);
    issue("R10_equal_copy", 5'd7, 5'd3, 16'd0, 0, 0, 0, 0, 2'b00, 0, 0);
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule